// File: doc/BRIEF.md
# Random Bit Statistical Health Tester

This block watches a serial stream of raw random bits and grades each fixed-length window of that stream with a set of on-line statistical checks. It counts ones (monobit). It counts runs of zeros and runs of ones in six length classes: 1, 2, 3, 4, 5, and 6 or longer. It computes a poker statistic over 4-bit nibbles. It watches the longest run of either value and the longest run of zeros (sparse check). It also counts ticks from an oscillator-derived strobe over the same window.

Each windowed statistic is held against a programmable upper bound and a programmable range. The lower bound is the upper bound minus the range. When a window closes, the block raises a one-cycle completion pulse and publishes a 17-bit failure vector. A pass flag goes with it and is high only when no check failed. All limits and the window length come from a write-only configuration port. Every limit has a power-up default.

Top module: `rbt_health_tester`

## Requirements
- R1: While reset is held and after it is released, `done`, `pass` and every bit of `fail_vec` are 0 until the first window closes.
- R2: A window closes on the accepted bit that brings the number of accepted bits in the current window to the window length. A bit is accepted when `bit_valid` is high and `cfg_we` is low. `done` is high for exactly the one cycle after that bit. Cycles with `bit_valid` low do not advance the window. The default window length is 2500.
- R3: Every banded statistic passes when (max − range) ≤ value ≤ max, both ends inclusive. When the range exceeds the max, the lower bound is 0.
- R4: The number of ones in the window is checked against the monobit band. A miss sets `fail_vec[15]`.
- R5: Each maximal run of equal bits is counted by polarity and length class k = min(length, 6) − 1. Runs continue across idle cycles and are cut at the window boundary. A zero-run count outside band k sets `fail_vec[2k]`, and a one-run count outside band k sets `fail_vec[2k+1]`.
- R6: A run of either polarity longer than the longest-run limit sets `fail_vec[13]`.
- R7: A run of zeros longer than the sparse limit sets `fail_vec[12]`.
- R8: Accepted bits are grouped into non-overlapping nibbles, first bit as the MSB. Only complete nibbles are counted. The sum over the 16 values of (count of that value)² is checked against the poker band, and a miss sets `fail_vec[14]`.
- R9: `osc_tick` cycles are counted from the cycle after the previous window closed (or after reset, or after a configuration write) through the closing cycle. A count below the minimum or above the maximum sets `fail_vec[16]`.
- R10: A configuration write stores `cfg_wdata` at `cfg_addr`. The address map and defaults are:
  - 0: window length (2500)
  - 1: monobit max (1384)
  - 2: monobit range (268)
  - 3: poker max (26912)
  - 4: poker range (2467)
  - 5: longest-run limit (34)
  - 6: sparse limit (63)
  - 7: tick minimum (1600)
  - 8: tick maximum (25600)
  - 9+2k: run max for class k (405, 220, 125, 75, 47, 47 for k = 0..5)
  - 10+2k: run range for class k (178, 122, 88, 64, 46, 46)

  Any write restarts the current window with all counts cleared. A bit or tick in the write cycle is discarded.
- R11: `fail_vec` and `pass` change only together with `done` and hold until the next window closes. `pass` equals 1 exactly when the new `fail_vec` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Qualifies `bit_in` this cycle |
| bit_in | input | 1 | Raw random bit |
| osc_tick | input | 1 | Oscillator count strobe, one tick per high cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW (5) | Configuration register index |
| cfg_wdata | input | DW (16) | Configuration write data |
| done | output | 1 | One-cycle window completion pulse |
| pass | output | 1 | Last window passed every check |
| fail_vec | output | 17 | Per-check failure flags of the last window |

## Verification
The hardest situation to reach from the ports is a window that closes on a bit that starts a new run. In that cycle two runs end at once, with different polarities and classes. The same cycle has a poker nibble that may or may not be complete. The bench gets there by shrinking the window through the configuration port and driving hand-built patterns whose final run is cut by the boundary, with idle gaps placed inside runs. It programs zero-width bands (range 0) so that one extra or missing count flips the flag. The window restart is driven by a configuration write one bit short of a window close, while ticks are still arriving.

// File: rtl/rbt_pkg.sv
package rbt_pkg;
   localparam int NCLASS   = 6;
   localparam int NRUNF    = 2 * NCLASS;
   localparam int FAILW    = 17;
   localparam int NREG     = 21;

   localparam int A_WIN    = 0;
   localparam int A_MMAX   = 1;
   localparam int A_MRNG   = 2;
   localparam int A_PMAX   = 3;
   localparam int A_PRNG   = 4;
   localparam int A_LONG   = 5;
   localparam int A_SPARSE = 6;
   localparam int A_FMIN   = 7;
   localparam int A_FMAX   = 8;
   localparam int A_RUN    = 9;

   function automatic int unsigned run_max_default(input int unsigned k);
      case (k)
         0: return 405;
         1: return 220;
         2: return 125;
         3: return 75;
         default: return 47;
      endcase
   endfunction

   function automatic int unsigned run_rng_default(input int unsigned k);
      case (k)
         0: return 178;
         1: return 122;
         2: return 88;
         3: return 64;
         default: return 46;
      endcase
   endfunction

   function automatic int unsigned cfg_default(input int unsigned idx);
      case (idx)
         A_WIN:    return 2500;
         A_MMAX:   return 1384;
         A_MRNG:   return 268;
         A_PMAX:   return 26912;
         A_PRNG:   return 2467;
         A_LONG:   return 34;
         A_SPARSE: return 63;
         A_FMIN:   return 1600;
         A_FMAX:   return 25600;
         default: begin
            if ((idx - A_RUN) % 2 == 0) return run_max_default((idx - A_RUN) / 2);
            else                        return run_rng_default((idx - A_RUN) / 2);
         end
      endcase
   endfunction

   // inclusive band check; lower edge is derived, clamped at zero
   function automatic logic in_band(input logic [31:0] val,
                                    input logic [31:0] mx,
                                    input logic [31:0] rg);
      logic [31:0] lo;
      lo = (rg > mx) ? 32'd0 : mx - rg;
      return (val >= lo) && (val <= mx);
   endfunction
endpackage

// File: rtl/rbt_cfg_regs.sv
module rbt_cfg_regs
   import rbt_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [AW-1:0]             cfg_addr,
   input  logic [DW-1:0]             cfg_wdata,
   output logic [NREG-1:0][DW-1:0]   regs_q
);
   if ((1 << AW) < NREG) begin : g_bad_aw
      $error("rbt_cfg_regs: AW too small for the register file");
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [DW-1:0] RST_VAL = DW'(cfg_default(i));
      logic [DW-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                r <= RST_VAL;
         else if (cfg_we && cfg_addr == AW'(i))     r <= cfg_wdata;
      end
      assign regs_q[i] = r;

      // R10: a write to this index is visible the next cycle
      a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_we && cfg_addr == AW'(i) |=> r == $past(cfg_wdata));
   end
endmodule

// File: rtl/rbt_run_stats.sv
module rbt_run_stats
   import rbt_pkg::*;
#(
   parameter int CW  = 16,
   parameter int DW  = 16,
   parameter int RLW = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         acc,
   input  logic                         last,
   input  logic                         bit_in,
   input  logic [NCLASS-1:0][DW-1:0]    run_max,
   input  logic [NCLASS-1:0][DW-1:0]    run_rng,
   input  logic [DW-1:0]                long_lim,
   input  logic [DW-1:0]                sparse_lim,
   output logic [NRUNF-1:0]             run_fail,
   output logic                         long_fail,
   output logic                         sparse_fail
);
   localparam int CLSW = $clog2(NCLASS);

   if (RLW < 3) begin : g_bad_rlw
      $error("rbt_run_stats: RLW must cover the top length class");
   end

   logic            have_prev, prev_bit;
   logic [RLW-1:0]  run_len, cur_len;
   logic            long_seen, sparse_seen;
   logic            cont, end_a, long_hit, sparse_hit;
   logic [CLSW-1:0] cls_a, cls_b;

   function automatic logic [CLSW-1:0] len_class(input logic [RLW-1:0] l);
      if (l >= RLW'(NCLASS)) return CLSW'(NCLASS - 1);
      return CLSW'(l - RLW'(1));
   endfunction

   always_comb begin
      cont       = have_prev && (bit_in == prev_bit);
      cur_len    = cont ? ((run_len == '1) ? run_len : run_len + RLW'(1)) : RLW'(1);
      end_a      = acc && have_prev && !cont;     // previous run closes
      cls_a      = len_class(run_len);
      cls_b      = len_class(cur_len);             // run closed by window end
      long_hit   = acc && (32'(cur_len) > 32'(long_lim));
      sparse_hit = acc && !bit_in && (32'(cur_len) > 32'(sparse_lim));
   end

   assign long_fail   = long_seen   | long_hit;
   assign sparse_fail = sparse_seen | sparse_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev <= 1'b0; prev_bit <= 1'b0; run_len <= '0;
         long_seen <= 1'b0; sparse_seen <= 1'b0;
      end else if (clr || last) begin
         have_prev <= 1'b0; prev_bit <= 1'b0; run_len <= '0;
         long_seen <= 1'b0; sparse_seen <= 1'b0;
      end else if (acc) begin
         have_prev   <= 1'b1;
         prev_bit    <= bit_in;
         run_len     <= cur_len;
         long_seen   <= long_seen | long_hit;
         sparse_seen <= sparse_seen | sparse_hit;
      end
   end

   for (genvar p = 0; p < 2; p++) begin : g_pol
      for (genvar k = 0; k < NCLASS; k++) begin : g_cls
         logic [CW-1:0] cnt, cnt_nx;
         logic          inc_a, inc_b;
         assign inc_a  = end_a && (prev_bit == 1'(p)) && (cls_a == CLSW'(k));
         assign inc_b  = last  && (bit_in   == 1'(p)) && (cls_b == CLSW'(k));
         assign cnt_nx = cnt + CW'(inc_a) + CW'(inc_b);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt <= '0;
            else if (clr || last)   cnt <= '0;
            else                    cnt <= cnt_nx;
         end
         assign run_fail[2*k+p] = !in_band(32'(cnt_nx), 32'(run_max[k]), 32'(run_rng[k]));
      end
   end

   // R5: an accepted bit inside a window becomes the tracked run value
   a_r5_prev_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !clr && !last |=> have_prev && prev_bit == $past(bit_in));
   // R6: an over-long run stays recorded until the window ends
   a_r6_long_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      long_seen && !clr && !last |=> long_seen);
endmodule

// File: rtl/rbt_count_stats.sv
module rbt_count_stats
   import rbt_pkg::*;
#(
   parameter int CW = 16,
   parameter int DW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            acc,
   input  logic            last,
   input  logic            bit_in,
   input  logic            osc_tick,
   input  logic [DW-1:0]   mono_max,
   input  logic [DW-1:0]   mono_rng,
   input  logic [DW-1:0]   pkr_max,
   input  logic [DW-1:0]   pkr_rng,
   input  logic [DW-1:0]   fmin,
   input  logic [DW-1:0]   fmax,
   output logic            mono_fail,
   output logic            poker_fail,
   output logic            freq_fail
);
   localparam int PW   = 2 * CW;
   localparam int NVAL = 16;

   logic [CW-1:0]            ones, ones_nx, ticks, ticks_nx;
   logic [2:0]               nib_sh;
   logic [1:0]               nib_pos;
   logic [PW-1:0]            psum, psum_nx;
   logic [NVAL-1:0][CW-1:0]  ncnt;
   logic                     nib_done;
   logic [3:0]               nib_val;

   assign nib_done = acc && (nib_pos == 2'd3);
   assign nib_val  = {nib_sh, bit_in};
   assign ones_nx  = ones + CW'(acc && bit_in);
   assign ticks_nx = (osc_tick && !clr && ticks != '1) ? ticks + CW'(1) : ticks;
   // (c+1)^2 - c^2 = 2c+1 keeps the sum of squares without a multiplier
   assign psum_nx  = nib_done ? psum + PW'({ncnt[nib_val], 1'b1}) : psum;

   assign mono_fail  = !in_band(32'(ones_nx), 32'(mono_max), 32'(mono_rng));
   assign poker_fail = !in_band(32'(psum_nx), 32'(pkr_max), 32'(pkr_rng));
   assign freq_fail  = (32'(ticks_nx) < 32'(fmin)) || (32'(ticks_nx) > 32'(fmax));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones <= '0; ticks <= '0; psum <= '0; nib_sh <= '0; nib_pos <= '0;
      end else if (clr || last) begin
         ones <= '0; ticks <= '0; psum <= '0; nib_sh <= '0; nib_pos <= '0;
      end else begin
         ones  <= ones_nx;
         ticks <= ticks_nx;
         psum  <= psum_nx;
         if (acc) begin
            nib_pos <= nib_pos + 2'd1;
            nib_sh  <= {nib_sh[1:0], bit_in};
         end
      end
   end

   for (genvar v = 0; v < NVAL; v++) begin : g_nib
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          ncnt[v] <= '0;
         else if (clr || last)                ncnt[v] <= '0;
         else if (nib_done && nib_val == 4'(v)) ncnt[v] <= ncnt[v] + CW'(1);
      end
   end

   // R8: the poker sum never shrinks inside a window
   a_r8_psum_grows: assert property (@(posedge clk) disable iff (!rst_n)
      !clr && !last |=> psum >= $past(psum));
   // R4: the ones count moves by at most one per cycle inside a window
   a_r4_ones_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clr && !last |=> (ones == $past(ones)) || (ones == $past(ones) + CW'(1)));
endmodule

// File: rtl/rbt_health_tester.sv
module rbt_health_tester
   import rbt_pkg::*;
#(
   parameter int CW  = 16,
   parameter int DW  = 16,
   parameter int AW  = 5,
   parameter int RLW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_valid,
   input  logic               bit_in,
   input  logic               osc_tick,
   input  logic               cfg_we,
   input  logic [AW-1:0]      cfg_addr,
   input  logic [DW-1:0]      cfg_wdata,
   output logic               done,
   output logic               pass,
   output logic [FAILW-1:0]   fail_vec
);
   if (CW < 12 || CW > 16) begin : g_bad_cw
      $error("rbt_health_tester: CW must lie in 12..16");
   end
   if (DW < 15 || DW > 32) begin : g_bad_dw
      $error("rbt_health_tester: DW must lie in 15..32");
   end

   logic [NREG-1:0][DW-1:0]   regs_q;
   logic [NCLASS-1:0][DW-1:0] run_max, run_rng;
   logic [CW-1:0]             wcnt;
   logic                      acc, last;
   logic [NRUNF-1:0]          run_fail;
   logic                      long_fail, sparse_fail, mono_fail, poker_fail, freq_fail;
   logic [FAILW-1:0]          fail_now;

   rbt_cfg_regs #(.DW(DW), .AW(AW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .regs_q(regs_q));

   for (genvar k = 0; k < NCLASS; k++) begin : g_lim
      assign run_max[k] = regs_q[A_RUN + 2*k];
      assign run_rng[k] = regs_q[A_RUN + 2*k + 1];
   end

   assign acc  = bit_valid && !cfg_we;
   assign last = acc && ((32'(wcnt) + 32'd1) >= 32'(regs_q[A_WIN]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              wcnt <= '0;
      else if (cfg_we || last) wcnt <= '0;
      else if (acc)            wcnt <= wcnt + CW'(1);
   end

   rbt_run_stats #(.CW(CW), .DW(DW), .RLW(RLW)) u_runs (
      .clk(clk), .rst_n(rst_n), .clr(cfg_we), .acc(acc), .last(last), .bit_in(bit_in),
      .run_max(run_max), .run_rng(run_rng),
      .long_lim(regs_q[A_LONG]), .sparse_lim(regs_q[A_SPARSE]),
      .run_fail(run_fail), .long_fail(long_fail), .sparse_fail(sparse_fail));

   rbt_count_stats #(.CW(CW), .DW(DW)) u_counts (
      .clk(clk), .rst_n(rst_n), .clr(cfg_we), .acc(acc), .last(last), .bit_in(bit_in),
      .osc_tick(osc_tick),
      .mono_max(regs_q[A_MMAX]), .mono_rng(regs_q[A_MRNG]),
      .pkr_max(regs_q[A_PMAX]), .pkr_rng(regs_q[A_PRNG]),
      .fmin(regs_q[A_FMIN]), .fmax(regs_q[A_FMAX]),
      .mono_fail(mono_fail), .poker_fail(poker_fail), .freq_fail(freq_fail));

   assign fail_now = {freq_fail, mono_fail, poker_fail, long_fail, sparse_fail, run_fail};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0; pass <= 1'b0; fail_vec <= '0;
      end else begin
         done <= last;
         if (last) begin
            fail_vec <= fail_now;
            pass     <= ~|fail_now;
         end
      end
   end

   // R2: a completion pulse always follows an accepted bit
   a_r2_done_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(acc));
   // R10: a configuration write never closes a window
   a_r10_cfg_restart: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> !done);
   // R11: pass agrees with the published vector
   a_r11_pass_match: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pass == (fail_vec == '0)));
   // R11: results hold between window closes
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !last |=> $stable(fail_vec) && $stable(pass));
endmodule

// File: tb/sim_rbt_health_tester.sv
module sim_rbt_health_tester;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_valid = 1'b0, bit_in = 1'b0, osc_tick = 1'b0, cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        done, pass;
   logic [16:0] fail_vec;

   int n_checks = 0;
   int n_err    = 0;
   int lim[21];
   int m_run[2][6];
   logic q_bits[$];

   always #10 clk = ~clk;

   rbt_health_tester u0 (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .osc_tick(osc_tick), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .done(done), .pass(pass), .fail_vec(fail_vec));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic band(int v, int mx, int rg);
      int lo;
      lo = (rg > mx) ? 0 : mx - rg;
      return (v >= lo) && (v <= mx);
   endfunction

   function automatic void add_run(logic p, int len);
      int k;
      k = (len >= 6) ? 5 : len - 1;
      m_run[int'(p)][k]++;
   endfunction

   function automatic logic [16:0] model(int ticks);
      logic [16:0] f;
      int n, ones, len, longest, zlong, psum;
      int nc[16];
      f = '0; n = q_bits.size(); ones = 0; len = 0; longest = 0; zlong = 0; psum = 0;
      for (int p = 0; p < 2; p++) for (int k = 0; k < 6; k++) m_run[p][k] = 0;
      for (int v = 0; v < 16; v++) nc[v] = 0;
      for (int i = 0; i < n; i++) begin
         if (q_bits[i]) ones++;
         if (i > 0 && q_bits[i] == q_bits[i-1]) len++;
         else begin
            if (i > 0) add_run(q_bits[i-1], len);
            len = 1;
         end
         if (len > longest) longest = len;
         if (!q_bits[i] && len > zlong) zlong = len;
      end
      if (n > 0) add_run(q_bits[n-1], len);
      for (int j = 0; j + 3 < n; j += 4)
         nc[int'({q_bits[j], q_bits[j+1], q_bits[j+2], q_bits[j+3]})]++;
      for (int v = 0; v < 16; v++) psum += nc[v] * nc[v];
      for (int k = 0; k < 6; k++) begin
         f[2*k]   = !band(m_run[0][k], lim[9+2*k], lim[10+2*k]);
         f[2*k+1] = !band(m_run[1][k], lim[9+2*k], lim[10+2*k]);
      end
      f[12] = zlong > lim[6];
      f[13] = longest > lim[5];
      f[14] = !band(psum, lim[3], lim[4]);
      f[15] = !band(ones, lim[1], lim[2]);
      f[16] = (ticks < lim[7]) || (ticks > lim[8]);
      return f;
   endfunction

   task automatic cfg_write(int a, int d);
      @(negedge clk);
      bit_valid = 1'b0; osc_tick = 1'b0;
      cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
      @(negedge clk);
      cfg_we = 1'b0;
      lim[a] = d;
   endtask

   // drives q_bits as one window; returns observed vector
   task automatic run_window(string tag, int ticks_n, int gap_at, int gap_len,
                             output logic [16:0] got);
      int tk, early;
      logic [16:0] e;
      tk = 0; early = 0;
      for (int i = 0; i < q_bits.size(); i++) begin
         if (i == gap_at) begin
            for (int g = 0; g < gap_len; g++) begin
               @(negedge clk);
               if (done) early++;
               bit_valid = 1'b0; osc_tick = 1'b1; tk++;
            end
         end
         @(negedge clk);
         if (done) early++;
         bit_valid = 1'b1; bit_in = q_bits[i];
         osc_tick = (i < ticks_n);
         if (i < ticks_n) tk++;
      end
      @(negedge clk);
      bit_valid = 1'b0; osc_tick = 1'b0;
      e = model(tk);
      got = fail_vec;
      check({tag, " R2 done at close"}, 32'(done), 32'd1);
      check({tag, " fail_vec"}, 32'(fail_vec), 32'(e));
      check({tag, " R11 pass"}, 32'(pass), 32'(e == '0));
      @(negedge clk);
      check({tag, " R2 single pulse"}, 32'(done), 32'd0);
      check({tag, " R2 no early close"}, 32'(early), 32'd0);
   endtask

   task automatic fill_pattern(string s);
      q_bits.delete();
      foreach (s[i]) q_bits.push_back(s[i] == "1");
   endtask

   task automatic t_reset();
      check("R1 done after reset", 32'(done), 32'd0);
      check("R1 pass after reset", 32'(pass), 32'd0);
      check("R1 fail_vec after reset", 32'(fail_vec), 32'd0);
   endtask

   task automatic t_default();
      logic [15:0] lfsr;
      logic [16:0] got;
      lfsr = 16'hACE1;
      q_bits.delete();
      for (int i = 0; i < 2500; i++) begin
         q_bits.push_back(lfsr[0]);
         lfsr = lfsr[0] ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
      end
      run_window("R10 default limits 2500 bits", 2000, -1, 0, got);
   endtask

   task automatic t_band();
      logic [16:0] got;
      int ks[4] = '{5, 6, 8, 9};
      logic exp[4] = '{1'b1, 1'b0, 1'b0, 1'b1};
      cfg_write(0, 16); cfg_write(1, 8); cfg_write(2, 2);
      foreach (ks[j]) begin
         q_bits.delete();
         for (int i = 0; i < 16; i++) q_bits.push_back(i < ks[j]);
         run_window("R3 R4 monobit band", 16, -1, 0, got);
         check("R3 monobit edge bit15", 32'(got[15]), 32'(exp[j]));
      end
   endtask

   task automatic t_runs();
      logic [16:0] got;
      cfg_write(0, 32);
      for (int k = 0; k < 6; k++) begin
         cfg_write(9 + 2*k, 1);
         cfg_write(10 + 2*k, 0);
      end
      fill_pattern("10011100001111100000011111110000");
      run_window("R5 run classes", 32, -1, 0, got);
      check("R5 run flags", 32'(got[11:0]), 32'h1D9);
      run_window("R5 run classes with idle gap", 32, 12, 3, got);
      check("R5 run flags across gap", 32'(got[11:0]), 32'h1D9);
   endtask

   task automatic t_long();
      logic [16:0] got;
      cfg_write(0, 40);
      q_bits.delete();
      for (int i = 0; i < 40; i++) q_bits.push_back(1'b1);
      run_window("R6 long run over limit", 40, -1, 0, got);
      check("R6 bit13 set", 32'(got[13]), 32'd1);
      cfg_write(5, 40);
      run_window("R6 long run at limit", 40, -1, 0, got);
      check("R6 bit13 clear", 32'(got[13]), 32'd0);
      cfg_write(5, 34);
   endtask

   task automatic t_sparse();
      logic [16:0] got;
      cfg_write(0, 32); cfg_write(6, 10);
      fill_pattern("00000000000010101010101010101010");
      run_window("R7 zero run over limit", 32, -1, 0, got);
      check("R7 bit12 set", 32'(got[12]), 32'd1);
      fill_pattern("11111111111101010101010101010101");
      run_window("R7 one run ignored", 32, -1, 0, got);
      check("R7 bit12 clear", 32'(got[12]), 32'd0);
   endtask

   task automatic t_poker();
      logic [16:0] got;
      cfg_write(0, 18); cfg_write(3, 16); cfg_write(4, 0);
      fill_pattern("101010101010101010");
      run_window("R8 poker equal nibbles", 18, -1, 0, got);
      check("R8 bit14 clear", 32'(got[14]), 32'd0);
      fill_pattern("101010100101001110");
      run_window("R8 poker mixed nibbles", 18, -1, 0, got);
      check("R8 bit14 set", 32'(got[14]), 32'd1);
   endtask

   task automatic t_freq();
      logic [16:0] got;
      int tn[4] = '{3, 4, 8, 9};
      logic exp[4] = '{1'b1, 1'b0, 1'b0, 1'b1};
      cfg_write(0, 16); cfg_write(7, 4); cfg_write(8, 8);
      fill_pattern("0110100110010110");
      foreach (tn[j]) begin
         run_window("R9 tick window", tn[j], -1, 0, got);
         check("R9 bit16", 32'(got[16]), 32'(exp[j]));
      end
      run_window("R9 ticks during idle gap", 5, 6, 3, got);
      check("R9 bit16 with gap ticks", 32'(got[16]), 32'd0);
   endtask

   task automatic t_restart();
      logic [16:0] got;
      int early;
      early = 0;
      fill_pattern("0110100110010110");
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         if (done) early++;
         bit_valid = 1'b1; bit_in = q_bits[i]; osc_tick = 1'b1;
      end
      cfg_write(7, 4);
      @(negedge clk);
      if (done) early++;
      check("R10 write restarts window", 32'(early), 32'd0);
      run_window("R10 after restart", 4, -1, 0, got);
      check("R10 ticks cleared by write", 32'(got[16]), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 21; i++) lim[i] = 0;
      lim[0] = 2500; lim[1] = 1384; lim[2] = 268; lim[3] = 26912; lim[4] = 2467;
      lim[5] = 34; lim[6] = 63; lim[7] = 1600; lim[8] = 25600;
      lim[9]  = 405; lim[10] = 178; lim[11] = 220; lim[12] = 122;
      lim[13] = 125; lim[14] = 88;  lim[15] = 75;  lim[16] = 64;
      lim[17] = 47;  lim[18] = 46;  lim[19] = 47;  lim[20] = 46;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_default();
      t_band();
      t_runs();
      t_long();
      t_sparse();
      t_poker();
      t_freq();
      t_restart();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end

   initial begin
      #(20 * 100000);
      n_err++;
      $display("FAIL R2 watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end
endmodule